// File: doc/BRIEF.md
# ADC Multiplexer Frame Sequencer

This block paces a multiplexed sampling front end. Time is counted in converter cycles, each marked by a one-clock `cyc_tick`. A fixed number of cycles makes one conversion, and a fixed number of conversions makes one mux frame. With the defaults, three cycles per conversion and four conversions per frame give a twelve-cycle frame, and that count includes the settling cycle. The block presents the input-select index of the conversion in progress. It pulses a strobe when each conversion completes and pulses a frame marker on the last cycle of every frame. It also drives a chopper polarity that downstream arithmetic uses to cancel offsets.

A host may pulse `alt_req` at any time to ask for one alternate frame, for example a frame that reads a temperature sensor. The request is held until the current frame ends. The next frame then runs as an alternate frame, and `alt_frame` stays high for exactly that frame. The chopper polarity inverts on every conversion. It also holds still across the end of each alternate frame. Because of this, successive alternate frames start with opposite polarity even though a frame holds an even number of conversions. A synchronous clear returns the sequencer to the start of a normal frame.

Top module: `mux_frame_seq`

## Requirements
- R1: After the asynchronous reset is released, `sel_idx` is 0, `alt_frame` is 0, `chop_pol` is 0, and neither `conv_strobe` nor `frame_end` is high while `cyc_tick` is low.
- R2: The cycle and conversion counters advance only on clocks where `cyc_tick` is 1. While `cyc_tick` is 0, `sel_idx`, `chop_pol` and `alt_frame` hold, and no strobe is raised.
- R3: `conv_strobe` is high, combinationally, on every N_CYC-th tick, counted from the start of a conversion. On the following clock, `sel_idx` steps by one and wraps from N_CONV-1 to 0.
- R4: `frame_end` is high for one clock on the tick that completes conversion N_CONV-1, which makes it every N_CYC*N_CONV ticks. This holds for normal and for alternate frames, and `frame_end` is always high together with `conv_strobe`.
- R5: After every conversion strobe, `chop_pol` inverts on the next clock. The single exception is the strobe that ends an alternate frame (see R8).
- R6: An `alt_req` pulse on any clock, with or without a tick, makes the frame that starts after the next `frame_end` an alternate frame. A pulse on the same clock as `frame_end` counts for the frame that begins right after it. `alt_frame` is 1 for exactly that frame's N_CYC*N_CONV ticks.
- R7: Any number of `alt_req` pulses that arrive inside one frame insert only one alternate frame.
- R8: At the end of an alternate frame, `chop_pol` holds instead of inverting. As a result, successive alternate frames begin with opposite chopper polarity (0 for the first one after reset, then 1, then 0).
- R9: `sync_clr` takes priority over `cyc_tick` and `alt_req`. On the next clock it returns `sel_idx`, `alt_frame` and `chop_pol` to 0, restarts the cycle count, and discards any pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| sync_clr | input | 1 | Synchronous restart to the first cycle of a normal frame |
| cyc_tick | input | 1 | One converter cycle elapses on this clock |
| alt_req | input | 1 | Host pulse requesting one alternate frame |
| sel_idx | output | $clog2(N_CONV) | Input-select index of the conversion in progress |
| conv_strobe | output | 1 | Conversion completes on this clock |
| frame_end | output | 1 | Last cycle of the frame |
| alt_frame | output | 1 | Current frame is an alternate frame |
| chop_pol | output | 1 | Chopper polarity |

## Verification
`conv_strobe` and `frame_end` are combinational from the counter state and `cyc_tick`, so they are due in the same clock as the tick that completes a conversion. The bench drives inputs just after a falling edge and samples these strobes one time unit later, before the rising edge. `sel_idx`, `chop_pol` and `alt_frame` are registered and change one rising edge after the strobe or clear that causes them, so the bench samples them one time unit after that edge. A request raised mid-frame has no visible effect until the clock after the next `frame_end`, and the bench checks `alt_frame` at both ends of that window.

// File: rtl/mfs_pkg.sv
package mfs_pkg;
  typedef enum logic {
    FRAME_NORMAL = 1'b0,
    FRAME_ALT    = 1'b1
  } frame_kind_e;
endpackage

// File: rtl/mfs_cycle_cnt.sv
module mfs_cycle_cnt #(
  parameter int N_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic conv_done
);
  localparam int CYC_W = (N_CYC > 1) ? $clog2(N_CYC) : 1;
  localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(N_CYC - 1);

  logic [CYC_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             at_last;

  assign at_last   = (cnt_q == CYC_LAST);
  assign conv_done = tick & at_last & ~clr;
  assign cnt_en    = clr | tick;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)          cnt_d = '0;
    else if (at_last) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/mfs_conv_cnt.sv
module mfs_conv_cnt #(
  parameter int N_CONV = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      adv,
  output logic [$clog2(N_CONV)-1:0] idx,
  output logic                      last_conv,
  output logic                      samp_par
);
  localparam int IDX_W = $clog2(N_CONV);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(N_CONV - 1);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic             par_q, par_d;
  logic             upd_en;

  assign upd_en    = clr | adv;
  assign last_conv = (idx_q == IDX_LAST);

  always_comb begin
    idx_d = idx_q;
    par_d = par_q;
    if (clr) begin
      idx_d = '0;
      par_d = 1'b0;
    end else begin
      idx_d = last_conv ? '0 : idx_q + 1'b1;
      par_d = ~par_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      par_q <= 1'b0;
    end else if (upd_en) begin
      idx_q <= idx_d;
      par_q <= par_d;
    end
  end

  assign idx      = idx_q;
  assign samp_par = par_q;
endmodule

// File: rtl/mfs_frame_ctl.sv
module mfs_frame_ctl
  import mfs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic req,
  input  logic frm_done,
  output logic is_alt,
  output logic alt_par
);
  frame_kind_e kind_q, kind_d;
  logic        pend_q, pend_d;
  logic        apar_q, apar_d;

  always_comb begin
    kind_d = kind_q;
    pend_d = pend_q;
    apar_d = apar_q;
    if (clr) begin
      kind_d = FRAME_NORMAL;
      pend_d = 1'b0;
      apar_d = 1'b0;
    end else if (frm_done) begin
      kind_d = (pend_q | req) ? FRAME_ALT : FRAME_NORMAL;
      pend_d = 1'b0;
      if (kind_q == FRAME_ALT) apar_d = ~apar_q;
    end else begin
      pend_d = pend_q | req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= FRAME_NORMAL;
      pend_q <= 1'b0;
      apar_q <= 1'b0;
    end else begin
      kind_q <= kind_d;
      pend_q <= pend_d;
      apar_q <= apar_d;
    end
  end

  assign is_alt  = (kind_q == FRAME_ALT);
  assign alt_par = apar_q;
endmodule

// File: rtl/mux_frame_seq.sv
module mux_frame_seq #(
  parameter int N_CYC  = 3,
  parameter int N_CONV = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sync_clr,
  input  logic                      cyc_tick,
  input  logic                      alt_req,
  output logic [$clog2(N_CONV)-1:0] sel_idx,
  output logic                      conv_strobe,
  output logic                      frame_end,
  output logic                      alt_frame,
  output logic                      chop_pol
);
  logic conv_done;
  logic last_conv;
  logic samp_par;
  logic alt_par;
  logic frm_done;

  mfs_cycle_cnt #(.N_CYC(N_CYC)) u_cyc (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (sync_clr),
    .tick      (cyc_tick),
    .conv_done (conv_done)
  );

  mfs_conv_cnt #(.N_CONV(N_CONV)) u_conv (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (sync_clr),
    .adv       (conv_done),
    .idx       (sel_idx),
    .last_conv (last_conv),
    .samp_par  (samp_par)
  );

  assign frm_done = conv_done & last_conv;

  mfs_frame_ctl u_frm (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (sync_clr),
    .req      (alt_req),
    .frm_done (frm_done),
    .is_alt   (alt_frame),
    .alt_par  (alt_par)
  );

  assign conv_strobe = conv_done;
  assign frame_end   = frm_done;
  assign chop_pol    = samp_par ^ alt_par;
endmodule

// File: rtl/mfs_chk.sv
module mfs_chk #(
  parameter int N_CONV = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      sync_clr,
  input logic                      cyc_tick,
  input logic [$clog2(N_CONV)-1:0] sel_idx,
  input logic                      conv_strobe,
  input logic                      frame_end,
  input logic                      alt_frame,
  input logic                      chop_pol
);
  localparam int IDX_W = $clog2(N_CONV);

  // R2: no tick, no strobe
  a_r2_strobe_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    conv_strobe |-> cyc_tick);

  // R2: state holds without a tick
  a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_tick && !sync_clr) |=> ($stable(sel_idx) && $stable(chop_pol) && $stable(alt_frame)));

  // R3: index steps after each conversion
  a_r3_index_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_strobe && !sync_clr) |=>
      (sel_idx == (($past(sel_idx) == IDX_W'(N_CONV-1)) ? '0 : $past(sel_idx) + 1'b1)));

  // R4: frame end only with the last conversion
  a_r4_end_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> (conv_strobe && sel_idx == IDX_W'(N_CONV-1)));

  // R5: polarity inverts per sample
  a_r5_chop_inverts: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_strobe && !sync_clr && !(frame_end && alt_frame)) |=> (chop_pol != $past(chop_pol)));

  // R6: frame kind changes only at a frame boundary
  a_r6_kind_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_end && !sync_clr) |=> $stable(alt_frame));

  // R8: polarity holds across the end of an alternate frame
  a_r8_alt_end_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && alt_frame && !sync_clr) |=> $stable(chop_pol));

  // R9: clear restores the start state
  a_r9_clear_state: assert property (@(posedge clk) disable iff (!rst_n)
    sync_clr |=> (sel_idx == '0 && !alt_frame && !chop_pol));
endmodule

bind mux_frame_seq mfs_chk #(.N_CONV(N_CONV)) u_mfs_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sync_clr    (sync_clr),
  .cyc_tick    (cyc_tick),
  .sel_idx     (sel_idx),
  .conv_strobe (conv_strobe),
  .frame_end   (frame_end),
  .alt_frame   (alt_frame),
  .chop_pol    (chop_pol)
);

// File: tb/mux_frame_seq_bench.sv
`timescale 1ns/1ps
module mux_frame_seq_bench;
  localparam int N_CYC  = 3;
  localparam int N_CONV = 4;
  localparam int IDX_W  = $clog2(N_CONV);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             sync_clr = 1'b0;
  logic             cyc_tick = 1'b0;
  logic             alt_req = 1'b0;
  logic [IDX_W-1:0] sel_idx;
  logic             conv_strobe, frame_end, alt_frame, chop_pol;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // expected state, derived from the requirements
  int m_cyc, m_conv, m_samp, m_altp, m_alt, m_pend;
  int cnt_fe, cnt_alt_frames;

  always #5 clk = ~clk;

  mux_frame_seq #(.N_CYC(N_CYC), .N_CONV(N_CONV)) u_mux_frame_seq (
    .clk(clk), .rst_n(rst_n), .sync_clr(sync_clr), .cyc_tick(cyc_tick),
    .alt_req(alt_req), .sel_idx(sel_idx), .conv_strobe(conv_strobe),
    .frame_end(frame_end), .alt_frame(alt_frame), .chop_pol(chop_pol)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_clear();
    m_cyc = 0; m_conv = 0; m_samp = 0; m_altp = 0; m_alt = 0; m_pend = 0;
  endtask

  // one clock: drive, check strobes before the edge, check state after it
  task automatic step(input string tag, input bit t, input bit r, input bit c);
    int es, ef;
    @(negedge clk);
    cyc_tick = t; alt_req = r; sync_clr = c;
    #1;
    es = (t && !c && m_cyc == N_CYC-1) ? 1 : 0;
    ef = (es == 1 && m_conv == N_CONV-1) ? 1 : 0;
    chk(tag, "conv_strobe", int'(conv_strobe), es);
    chk(tag, "frame_end", int'(frame_end), ef);
    if (ef == 1) cnt_fe++;
    if (c) model_clear();
    else begin
      if (ef == 1) begin
        if (m_alt == 1) m_altp ^= 1;
        m_alt = (m_pend == 1 || r) ? 1 : 0;
        if (m_alt == 1) cnt_alt_frames++;
        m_pend = 0;
      end else if (r) m_pend = 1;
      if (t) begin
        if (m_cyc == N_CYC-1) begin
          m_cyc = 0; m_samp ^= 1;
          m_conv = (m_conv == N_CONV-1) ? 0 : m_conv + 1;
        end else m_cyc++;
      end
    end
    @(posedge clk);
    #1;
    chk(tag, "sel_idx", int'(sel_idx), m_conv);
    chk(tag, "alt_frame", int'(alt_frame), m_alt);
    chk(tag, "chop_pol", int'(chop_pol), m_samp ^ m_altp);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    model_clear();
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R1", "sel_idx", int'(sel_idx), 0);
    chk("R1", "alt_frame", int'(alt_frame), 0);
    chk("R1", "chop_pol", int'(chop_pol), 0);
    chk("R1", "conv_strobe", int'(conv_strobe), 0);
    chk("R1", "frame_end", int'(frame_end), 0);
  endtask

  task automatic t_normal();  // R3 R4 R5
    cnt_fe = 0;
    for (int i = 0; i < 3*N_CYC*N_CONV; i++) step("R3", 1, 0, 0);
    chk("R4", "frame_end count", cnt_fe, 3);
  endtask

  task automatic t_gaps();    // R2
    for (int i = 0; i < 2*N_CYC*N_CONV; i++) begin
      step("R2", 1, 0, 0);
      if (i % 3 == 1) step("R2", 0, 0, 0);
      if (i % 5 == 2) begin step("R2", 0, 0, 0); step("R2", 0, 0, 0); end
    end
  endtask

  task automatic t_alt();     // R6 R8
    cnt_alt_frames = 0;
    for (int i = 0; i < 4; i++) step("R6", 1, 0, 0);
    step("R6", 0, 1, 0);       // request without a tick, mid frame
    chk("R6", "alt_frame before boundary", int'(alt_frame), 0);
    for (int i = 0; i < 4*N_CYC*N_CONV; i++) step("R8", 1, (i == 2*N_CYC*N_CONV + 1), 0);
    chk("R6", "alt frames inserted", cnt_alt_frames, 2);
    chk("R8", "alt polarity parity", m_altp, 0);
  endtask

  task automatic t_multi();    // R7
    cnt_alt_frames = 0;
    for (int i = 0; i < 3*N_CYC*N_CONV; i++) step("R7", 1, (i < 5), 0);
    chk("R7", "alt frames for many pulses", cnt_alt_frames, 1);
  endtask

  task automatic t_boundary(); // R6 request on the frame_end clock
    cnt_alt_frames = 0;
    while (!(m_cyc == N_CYC-1 && m_conv == N_CONV-1)) step("R6", 1, 0, 0);
    step("R6", 1, 1, 0);
    chk("R6", "alt right after boundary request", int'(alt_frame), 1);
    for (int i = 0; i < N_CYC*N_CONV; i++) step("R6", 1, 0, 0);
    chk("R6", "alt frame count", cnt_alt_frames, 1);
    chk("R6", "alt ended", int'(alt_frame), 0);
  endtask

  task automatic t_clear();    // R9
    for (int i = 0; i < 5; i++) step("R9", 1, (i == 1), 0);
    step("R9", 1, 1, 1);
    chk("R9", "sel_idx after clear", int'(sel_idx), 0);
    chk("R9", "chop_pol after clear", int'(chop_pol), 0);
    cnt_alt_frames = 0;
    for (int i = 0; i < 2*N_CYC*N_CONV; i++) step("R9", 1, 0, 0);
    chk("R9", "pending request dropped", cnt_alt_frames, 0);
  endtask

  initial begin
    t_reset();
    t_normal();
    t_gaps();
    t_alt();
    t_multi();
    t_boundary();
    t_clear();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule